// File: doc/BRIEF.md
# External Bus Request Driver

This block produces the active-low request line that a processing core presents to an external arbiter on a shared external bus. The core reports each memory access it is about to start, together with a flag that says whether the access targets the external bus or an internal one. Only external accesses count. While such an access is pending, the block pulls the request line low. When no external access remains, it releases the line. A hold bit under software control can keep the request asserted even when nothing is pending.

The block also keeps a simple record of bus ownership, either slave or master, and shows it on a flag output. The arbiter's grant can arrive from another clock domain, so it first passes through a synchronizer of configurable depth. Once the synchronized grant is seen while the request is asserted, the block becomes master. After that the request may drop while mastership is kept, which is bus parking. Mastership is given up only when the synchronized grant goes away and no external access is pending.

The request output is a flop, so it is glitch-free and always driven. A control module decides what happens next and passes a small set of strobes to a datapath module, which holds the request flop, the ownership flop and the grant synchronizer.

Top module: `brq_bus_request`

## Requirements
- R1: `busReqN` is driven from a register and is always 0 or 1, never high-impedance. Its value after a rising clock edge reflects the inputs sampled at that edge, so it is 0 (request asserted) or 1 (released).
- R2: If `coreReq`=1 and `coreExtSel`=1 at a clock edge, `busReqN` is 0 after that edge.
- R3: If at a clock edge there is no external access (`coreReq`=0 or `coreExtSel`=0) and `holdReq`=0, `busReqN` is 1 after that edge.
- R4: If `holdReq`=1 at a clock edge, `busReqN` is 0 after that edge, whether or not an access is pending.
- R5: An access with `coreExtSel`=0 (internal bus) has no effect on `busReqN` or `isMaster`. Both behave as if `coreReq` were 0.
- R6: While `rstN`=0, `busReqN` is 1, `isMaster` is 0 and the grant synchronizer is cleared, independent of the clock.
- R7: `busGrant` reaches the ownership logic through `GRANT_SYNC_STAGES` flops. A value of 0 means it is used directly.
- R8: A slave becomes master (`isMaster`=1) on the edge at which the synchronized grant is 1 while `busReqN` is 0. A grant seen while `busReqN` is 1 leaves the block a slave.
- R9: A master stays master as long as the synchronized grant is 1, even after `busReqN` returns to 1 (parking).
- R10: A master returns to slave on the edge at which the synchronized grant is 0 and no external access is pending. While an external access is pending it stays master, even with the grant removed.
- R11: `busReqN` follows R2 to R4 whether the block is currently master or slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| coreReq | input | 1 | Core has an access pending |
| coreExtSel | input | 1 | Pending access targets the external bus (1) or an internal bus (0) |
| holdReq | input | 1 | Software hold bit: keep the request asserted |
| busGrant | input | 1 | Grant from the external arbiter, active high, may be asynchronous |
| busReqN | output | 1 | Registered active-low bus request |
| isMaster | output | 1 | Block currently owns the external bus |

## Verification
The hardest state to reach from the ports is a master that has just lost its grant while an external access is still pending. To get there, the grant must already have crossed the synchronizer while the request was low. The pending access must then be held through the whole synchronizer delay after the grant drops, and the bench has to show that mastership survives until the access finishes. The stimulus builds this in stages: hold-driven request, grant, parking with the request released, a new pending access, and grant removal. After these directed stages, a long random phase and a reset while master follow. A behavioural model holding the grant history in a queue predicts both outputs on every cycle.

// File: rtl/brq_pkg.sv
package brq_pkg;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } brq_role_e;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic reqOn;      // request line should be asserted after this edge
    logic setMaster;  // take ownership at this edge
    logic clrMaster;  // give up ownership at this edge
  } brq_strobe_t;

endpackage

// File: rtl/brq_ctrl.sv
module brq_ctrl
  import brq_pkg::*;
(
  input  logic        coreReq,
  input  logic        coreExtSel,
  input  logic        holdReq,
  input  logic        grantSeen,
  input  logic        reqActive,
  input  brq_role_e   role,
  output brq_strobe_t strobe
);

  logic extNeed;

  // Only accesses aimed at the external bus count as a need.
  assign extNeed = coreReq & coreExtSel;

  always_comb begin
    strobe           = '0;
    strobe.reqOn     = extNeed | holdReq;
    strobe.setMaster = (role == ROLE_SLAVE) & grantSeen & reqActive;
    strobe.clrMaster = (role == ROLE_MASTER) & ~grantSeen & ~extNeed;
  end

endmodule

// File: rtl/brq_datapath.sv
module brq_datapath
  import brq_pkg::*;
#(
  parameter int GRANT_SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busGrant,
  input  brq_strobe_t strobe,
  output logic        busReqN,
  output brq_role_e   role,
  output logic        grantSeen,
  output logic        reqActive
);

  logic reqNQ;
  brq_role_e roleQ;

  generate
    if (GRANT_SYNC_STAGES == 0) begin : g_direct
      assign grantSeen = busGrant;
    end else begin : g_sync
      logic [GRANT_SYNC_STAGES-1:0] stage;
      for (genvar i = 0; i < GRANT_SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) stage[0] <= 1'b0;
            else       stage[0] <= busGrant;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) stage[i] <= 1'b0;
            else       stage[i] <= stage[i-1];
          end
        end
      end
      assign grantSeen = stage[GRANT_SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqNQ <= 1'b1;
    else       reqNQ <= ~strobe.reqOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 roleQ <= ROLE_SLAVE;
    else if (strobe.setMaster) roleQ <= ROLE_MASTER;
    else if (strobe.clrMaster) roleQ <= ROLE_SLAVE;
  end

  assign busReqN   = reqNQ;
  assign reqActive = ~reqNQ;
  assign role      = roleQ;

endmodule

// File: rtl/brq_bus_request.sv
module brq_bus_request
  import brq_pkg::*;
#(
  parameter int GRANT_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic coreReq,
  input  logic coreExtSel,
  input  logic holdReq,
  input  logic busGrant,
  output logic busReqN,
  output logic isMaster
);

  brq_strobe_t strobe;
  brq_role_e   role;
  logic        grantSeen;
  logic        reqActive;

  brq_ctrl u_ctrl (
    .coreReq    (coreReq),
    .coreExtSel (coreExtSel),
    .holdReq    (holdReq),
    .grantSeen  (grantSeen),
    .reqActive  (reqActive),
    .role       (role),
    .strobe     (strobe)
  );

  brq_datapath #(
    .GRANT_SYNC_STAGES (GRANT_SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busGrant  (busGrant),
    .strobe    (strobe),
    .busReqN   (busReqN),
    .role      (role),
    .grantSeen (grantSeen),
    .reqActive (reqActive)
  );

  assign isMaster = (role == ROLE_MASTER);

endmodule

// File: rtl/brq_bus_request_checker.sv
module brq_bus_request_checker (
  input logic clk,
  input logic rstN,
  input logic coreReq,
  input logic coreExtSel,
  input logic holdReq,
  input logic grantSeen,
  input logic busReqN,
  input logic isMaster
);

  logic extNeed;
  assign extNeed = coreReq & coreExtSel;

  a_r1_req_known: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(busReqN));

  a_r2_ext_asserts: assert property (@(posedge clk) disable iff (!rstN)
    extNeed |=> !busReqN);

  a_r3_idle_releases: assert property (@(posedge clk) disable iff (!rstN)
    (!extNeed && !holdReq) |=> busReqN);

  a_r4_hold_asserts: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |=> !busReqN);

  a_r5_internal_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && !coreExtSel && !holdReq) |=> busReqN);

  a_r8_take_ownership: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && grantSeen && !busReqN) |=> isMaster);

  a_r8_no_grant_no_master: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && !grantSeen) |=> !isMaster);

  a_r9_parked: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && grantSeen) |=> isMaster);

  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !grantSeen && !extNeed) |=> !isMaster);

  a_r10_keep_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && extNeed) |=> isMaster);

endmodule

bind brq_bus_request brq_bus_request_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .coreReq    (coreReq),
  .coreExtSel (coreExtSel),
  .holdReq    (holdReq),
  .grantSeen  (grantSeen),
  .busReqN    (busReqN),
  .isMaster   (isMaster)
);

// File: tb/brq_bus_request_test.sv
module brq_bus_request_test;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreReq = 1'b0;
  logic coreExtSel = 1'b0;
  logic holdReq = 1'b0;
  logic busGrant = 1'b0;
  logic busReqN;
  logic isMaster;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference
  bit mReq;
  bit mMaster;
  bit gq[$];

  always #4 clk = ~clk;

  brq_bus_request #(.GRANT_SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreExtSel(coreExtSel),
    .holdReq(holdReq), .busGrant(busGrant), .busReqN(busReqN), .isMaster(isMaster)
  );

  task automatic modelReset();
    mReq = 1'b0;
    mMaster = 1'b0;
    gq.delete();
    for (int i = 0; i < SYNC; i++) gq.push_back(1'b0);
  endtask

  task automatic compare(input string tag);
    checks++;
    if (busReqN !== !mReq) begin
      errors++;
      $display("FAIL %s busReqN actual=%b expected=%b", tag, busReqN, !mReq);
    end
    checks++;
    if (isMaster !== mMaster) begin
      errors++;
      $display("FAIL %s isMaster actual=%b expected=%b", tag, isMaster, mMaster);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, compare at next falling edge.
  task automatic tick(input bit r, input bit s, input bit h, input bit g, input string tag);
    bit ext;
    bit seen;
    coreReq = r; coreExtSel = s; holdReq = h; busGrant = g;
    @(posedge clk);
    ext  = r && s;
    seen = (SYNC == 0) ? g : gq[0];
    if (!mMaster && seen && mReq) mMaster = 1'b1;
    else if (mMaster && !seen && !ext) mMaster = 1'b0;
    mReq = ext || h;
    if (SYNC > 0) begin
      gq.push_back(g);
      void'(gq.pop_front());
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    modelReset();
    // R6: reset state
    repeat (3) begin
      @(negedge clk);
      compare("R6 reset");
    end
    // R6: reset holds even with activity on the inputs
    coreReq = 1'b1; coreExtSel = 1'b1; holdReq = 1'b1; busGrant = 1'b1;
    repeat (2) begin
      @(negedge clk);
      compare("R6 reset with inputs");
    end
    coreReq = 1'b0; coreExtSel = 1'b0; holdReq = 1'b0; busGrant = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R1/R2: external access asserts the request with registered latency
    tick(1, 1, 0, 0, "R2 ext pending");
    tick(1, 1, 0, 0, "R1 registered");
    // R3: release
    tick(0, 1, 0, 0, "R3 release");
    tick(0, 0, 0, 0, "R3 idle");
    // R5: internal accesses ignored, even with a grant present
    tick(1, 0, 0, 0, "R5 internal");
    tick(1, 0, 0, 1, "R5 internal grant");
    repeat (3) tick(1, 0, 0, 1, "R5 internal grant");
    // R8: grant without request leaves slave
    repeat (2) tick(0, 0, 0, 1, "R8 grant no req");
    tick(0, 0, 0, 0, "R8 grant off");
    repeat (SYNC + 1) tick(0, 0, 0, 0, "R7 drain");
    // R4: hold alone asserts
    tick(0, 0, 1, 0, "R4 hold");
    tick(0, 0, 1, 0, "R4 hold");
    // R7/R8: grant arrives through synchronizer, then ownership
    for (int i = 0; i < SYNC + 2; i++) tick(0, 0, 1, 1, "R7 R8 grant sync");
    // R9: parking with request released
    repeat (3) tick(0, 0, 0, 1, "R9 parked");
    // R11: request changes while master
    tick(1, 1, 0, 1, "R11 req as master");
    tick(0, 0, 0, 1, "R11 release as master");
    // R10: grant removed while external access pending keeps master
    tick(1, 1, 0, 0, "R10 busy keep");
    for (int i = 0; i < SYNC + 2; i++) tick(1, 1, 0, 0, "R10 busy keep");
    // R10: access ends, release ownership
    tick(0, 0, 0, 0, "R10 release");
    tick(0, 0, 0, 0, "R10 slave");
    // R10: internal access does not hold ownership (R5)
    repeat (2) tick(1, 1, 0, 1, "R8 regain");
    for (int i = 0; i < SYNC + 1; i++) tick(1, 1, 0, 1, "R8 regain");
    for (int i = 0; i < SYNC + 2; i++) tick(1, 0, 0, 0, "R5 R10 internal no hold");

    // R6: reset while master
    for (int i = 0; i < SYNC + 3; i++) tick(0, 0, 1, 1, "R8 regain hold");
    rstN = 1'b0;
    #1;
    modelReset();
    compare("R6 async reset as master");
    @(negedge clk);
    compare("R6 reset held");
    rstN = 1'b1;
    tick(0, 0, 0, 1, "R6 R7 sync cleared");

    // Mixed random traffic, all requirements
    for (int i = 0; i < 3000; i++) begin
      bit r, s, h, g;
      r = 1'($urandom);
      s = 1'($urandom);
      h = (($urandom % 8) == 0);
      g = (($urandom % 4) != 0);
      tick(r, s, h, g, "R1 R11 random");
    end

    finish();
  end

endmodule